// File: doc/BRIEF.md
# Serial Register Port for a Clock/Calendar Block

This block is the serial slave side of a small clock/calendar peripheral. The host raises chip select and sends an address byte. The top bit of that byte picks the direction and the low seven bits give the starting register. After that, data bytes stream to or from consecutive addresses until chip select drops. The block synchronises the serial pins into its own clock domain. It then steers each received byte into the correct storage region, or fetches the byte that the host will shift out next.

The register space covers several regions:
- time-of-day and date bytes, owned by an external counter that this block loads through a one-cycle write port;
- two four-byte alarm slots;
- a control byte;
- a status byte that reflects external alarm flags;
- a plain trickle-setting byte;
- ninety-six bytes of general RAM.

When a read burst starts, the block copies the seven time bytes into a shadow. A counter rollover during the burst therefore cannot produce torn values. A write-protect bit in the control byte locks every location except the control byte itself.

Top module: `spi_rtc_slave`

## Requirements
- R1: The first byte after chip select rises is an address byte. Bit 7 = 1 makes the burst a write and bit 7 = 0 makes it a read. Bits 6:0 give the starting address.
- R2: Each data byte after the address byte uses the next higher address. The address wraps from 0x7F to 0x00.
- R3: Chip select is active high and the clock idles low. MOSI is sampled on the falling clock edge and MISO changes on the rising edge, most significant bit first. MISO is 0 while chip select is low and during the address byte.
- R4: A permitted write to addresses 0x00–0x06 produces exactly one clock cycle of `time_we_o`. In that cycle `time_idx_o` holds the address and `time_wdata_o` holds the byte.
- R5: Reads of 0x00–0x06 return the values `time_i` held when the address byte of that read burst completed. Byte k of `time_i` is bits 8k+7:8k.
- R6: Addresses 0x07–0x0E are the alarm bytes, with byte (a−7) at `alarm_o` bits 8(a−7)+7:8(a−7). 0x0F is the control byte on `ctrl_o` and 0x11 is the trickle byte on `trickle_o`. 0x20–0x7F are RAM. All of these read back what was last written, and none change without a write.
- R7: Address 0x10 reads as {000000, `alarm_flag_i`}. Writes to it have no effect.
- R8: Addresses 0x12–0x1F read as 0x00. Writes to them have no effect.
- R9: While control bit 6 is 1, writes to every address except 0x0F are ignored, and no `time_we_o` pulse occurs.
- R10: After reset, every stored byte is 0x00, MISO is 0 and `time_we_o` is 0.
- R11: If chip select drops partway through a byte, the partial byte is discarded. The next transaction starts again with an address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock from host |
| cs_i | input | 1 | Chip select, active high |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| time_i | input | 56 | Live time bytes from the counter, byte k at bits 8k+7:8k |
| alarm_flag_i | input | 2 | Alarm match flags, shown in the status byte |
| time_we_o | output | 1 | One-cycle load strobe toward the time counter |
| time_idx_o | output | 3 | Time byte index for the load |
| time_wdata_o | output | 8 | Time byte value for the load |
| alarm_o | output | 64 | Both alarm slots, packed by address |
| ctrl_o | output | 8 | Control byte |
| trickle_o | output | 8 | Trickle setting byte |

## Verification
Some properties are checked on every cycle: byte framing gives at most one received-byte strobe in a row, the time load strobe lasts one cycle and its index stays within the time region, and write protect suppresses both time loads and alarm changes. The control byte also holds steady except right after a received byte, and MISO stays quiet while the chip is deselected. The directed scenarios are the only place where burst ordering, address wrap into the time region, the read snapshot under a changing counter, the zero reads from unmapped space and the recovery after an aborted byte can be shown.

// File: rtl/spi_rtc_pkg.sv
package spi_rtc_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 7;
  localparam int TIME_BASE = 'h00;
  localparam int TIME_N    = 7;
  localparam int ALM_BASE  = 'h07;
  localparam int ALM_N     = 8;
  localparam int CTRL_ADDR = 'h0F;
  localparam int STAT_ADDR = 'h10;
  localparam int TRKL_ADDR = 'h11;
  localparam int RAM_BASE  = 'h20;
  localparam int RAM_N     = 96;
  localparam int FLAG_N    = 2;
  localparam int WP_BIT    = 6;
  localparam int TIME_IW   = $clog2(TIME_N);
  localparam int ALM_IW    = $clog2(ALM_N);

  typedef enum logic [2:0] {
    RG_TIME, RG_ALARM, RG_CTRL, RG_STAT, RG_TRKL, RG_RAM, RG_NONE
  } region_e;

  function automatic region_e decode(input logic [ADDR_W-1:0] a);
    int v;
    v = int'(a);
    if (v >= TIME_BASE && v < TIME_BASE + TIME_N) return RG_TIME;
    if (v >= ALM_BASE && v < ALM_BASE + ALM_N)    return RG_ALARM;
    if (v == CTRL_ADDR)                           return RG_CTRL;
    if (v == STAT_ADDR)                           return RG_STAT;
    if (v == TRKL_ADDR)                           return RG_TRKL;
    if (v >= RAM_BASE && v < RAM_BASE + RAM_N)    return RG_RAM;
    return RG_NONE;
  endfunction
endpackage

// File: rtl/spi_rtc_shift.sv
module spi_rtc_shift #(
  parameter int DATA_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              cs_i,
  input  logic              mosi_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  output logic              cs_act_o,
  output logic              cs_start_o,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              miso_o
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  logic [SYNC_N-1:0] sck_sy, cs_sy, mosi_sy;
  logic              sck_s, cs_s, mosi_s, sck_d, cs_d;
  logic              rise, fall;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-2:0] rx_sh, tx_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_sy  <= '0;
      cs_sy   <= '0;
      mosi_sy <= '0;
      sck_d   <= 1'b0;
      cs_d    <= 1'b0;
    end else begin
      sck_sy  <= {sck_sy[SYNC_N-2:0], sck_i};
      cs_sy   <= {cs_sy[SYNC_N-2:0], cs_i};
      mosi_sy <= {mosi_sy[SYNC_N-2:0], mosi_i};
      sck_d   <= sck_s;
      cs_d    <= cs_s;
    end
  end

  assign sck_s  = sck_sy[SYNC_N-1];
  assign cs_s   = cs_sy[SYNC_N-1];
  assign mosi_s = mosi_sy[SYNC_N-1];
  assign rise   = sck_s & ~sck_d;
  assign fall   = ~sck_s & sck_d;

  assign cs_act_o   = cs_s;
  assign cs_start_o = cs_s & ~cs_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      rx_valid_o <= 1'b0;
      rx_byte_o  <= '0;
      miso_o     <= 1'b0;
    end else if (!cs_s) begin
      // deselect discards any partial byte
      cnt_q      <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      rx_valid_o <= 1'b0;
      miso_o     <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      if (fall) begin
        rx_sh <= {rx_sh[DATA_W-3:0], mosi_s};
        cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
        if (cnt_q == CNT_LAST) begin
          rx_valid_o <= 1'b1;
          rx_byte_o  <= {rx_sh, mosi_s};
        end
      end
      if (rise) begin
        if (cnt_q == '0) begin
          miso_o <= tx_byte_i[DATA_W-1];
          tx_sh  <= tx_byte_i[DATA_W-2:0];
        end else begin
          miso_o <= tx_sh[DATA_W-2];
          tx_sh  <= {tx_sh[DATA_W-3:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_rtc_regs.sv
module spi_rtc_regs
  import spi_rtc_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        wr_addr_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  input  logic                     snap_en_i,
  input  logic [TIME_N*DATA_W-1:0] time_i,
  input  logic [FLAG_N-1:0]        alarm_flag_i,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  output logic [DATA_W-1:0]        rd_data_o,
  output logic                     time_we_o,
  output logic [TIME_IW-1:0]       time_idx_o,
  output logic [DATA_W-1:0]        time_wdata_o,
  output logic [ALM_N*DATA_W-1:0]  alarm_o,
  output logic [DATA_W-1:0]        ctrl_o,
  output logic [DATA_W-1:0]        trickle_o
);
  logic [DATA_W-1:0] shadow_q [TIME_N];
  logic [DATA_W-1:0] alarm_q  [ALM_N];
  logic [DATA_W-1:0] ram_q    [RAM_N];
  logic [DATA_W-1:0] ctrl_q, trkl_q;

  region_e           wr_rg, rd_rg;
  logic              wr_ok;
  logic [ALM_IW-1:0] wr_alm, rd_alm;
  logic [ADDR_W-1:0] wr_ram, rd_ram;

  assign wr_rg  = decode(wr_addr_i);
  assign rd_rg  = decode(rd_addr_i);
  // control stays writable so protection can be lifted
  assign wr_ok  = wr_en_i & (~ctrl_q[WP_BIT] | (wr_rg == RG_CTRL));
  assign wr_alm = wr_addr_i[ALM_IW-1:0] - ALM_IW'(ALM_BASE);
  assign rd_alm = rd_addr_i[ALM_IW-1:0] - ALM_IW'(ALM_BASE);
  assign wr_ram = wr_addr_i - ADDR_W'(RAM_BASE);
  assign rd_ram = rd_addr_i - ADDR_W'(RAM_BASE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_we_o    <= 1'b0;
      time_idx_o   <= '0;
      time_wdata_o <= '0;
      ctrl_q       <= '0;
      trkl_q       <= '0;
      for (int k = 0; k < TIME_N; k++) shadow_q[k] <= '0;
      for (int k = 0; k < ALM_N; k++)  alarm_q[k]  <= '0;
      for (int k = 0; k < RAM_N; k++)  ram_q[k]    <= '0;
    end else begin
      time_we_o <= wr_ok & (wr_rg == RG_TIME);
      if (wr_ok && wr_rg == RG_TIME) begin
        time_idx_o   <= wr_addr_i[TIME_IW-1:0];
        time_wdata_o <= wr_data_i;
      end
      if (wr_ok) begin
        unique case (wr_rg)
          RG_ALARM: alarm_q[wr_alm] <= wr_data_i;
          RG_CTRL:  ctrl_q          <= wr_data_i;
          RG_TRKL:  trkl_q          <= wr_data_i;
          RG_RAM:   ram_q[wr_ram]   <= wr_data_i;
          default:  ;
        endcase
      end
      if (snap_en_i) begin
        for (int k = 0; k < TIME_N; k++) shadow_q[k] <= time_i[k*DATA_W +: DATA_W];
      end
    end
  end

  always_comb begin
    unique case (rd_rg)
      RG_TIME:  rd_data_o = shadow_q[rd_addr_i[TIME_IW-1:0]];
      RG_ALARM: rd_data_o = alarm_q[rd_alm];
      RG_CTRL:  rd_data_o = ctrl_q;
      RG_STAT:  rd_data_o = {{(DATA_W-FLAG_N){1'b0}}, alarm_flag_i};
      RG_TRKL:  rd_data_o = trkl_q;
      RG_RAM:   rd_data_o = ram_q[rd_ram];
      default:  rd_data_o = '0;
    endcase
  end

  for (genvar g = 0; g < ALM_N; g++) begin : g_alm
    assign alarm_o[g*DATA_W +: DATA_W] = alarm_q[g];
  end
  assign ctrl_o    = ctrl_q;
  assign trickle_o = trkl_q;
endmodule

// File: rtl/spi_rtc_slave.sv
module spi_rtc_slave
  import spi_rtc_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sck_i,
  input  logic                     cs_i,
  input  logic                     mosi_i,
  output logic                     miso_o,
  input  logic [TIME_N*DATA_W-1:0] time_i,
  input  logic [FLAG_N-1:0]        alarm_flag_i,
  output logic                     time_we_o,
  output logic [TIME_IW-1:0]       time_idx_o,
  output logic [DATA_W-1:0]        time_wdata_o,
  output logic [ALM_N*DATA_W-1:0]  alarm_o,
  output logic [DATA_W-1:0]        ctrl_o,
  output logic [DATA_W-1:0]        trickle_o
);
  logic              cs_act, cs_start, rx_valid;
  logic [DATA_W-1:0] rx_byte, tx_byte, rd_data;
  logic              first_q, wr_q;
  logic [ADDR_W-1:0] ptr_q;

  spi_rtc_shift #(.DATA_W(DATA_W), .SYNC_N(SYNC_N)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sck_i      (sck_i),
    .cs_i       (cs_i),
    .mosi_i     (mosi_i),
    .tx_byte_i  (tx_byte),
    .cs_act_o   (cs_act),
    .cs_start_o (cs_start),
    .rx_valid_o (rx_valid),
    .rx_byte_o  (rx_byte),
    .miso_o     (miso_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= 1'b1;
      wr_q    <= 1'b0;
      ptr_q   <= '0;
    end else if (cs_start) begin
      first_q <= 1'b1;
    end else if (rx_valid) begin
      if (first_q) begin
        first_q <= 1'b0;
        wr_q    <= rx_byte[DATA_W-1];
        ptr_q   <= rx_byte[ADDR_W-1:0];
      end else begin
        ptr_q   <= ptr_q + 1'b1;
      end
    end
  end

  assign tx_byte = (first_q | wr_q) ? '0 : rd_data;

  spi_rtc_regs u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (rx_valid & ~first_q & wr_q),
    .wr_addr_i    (ptr_q),
    .wr_data_i    (rx_byte),
    .snap_en_i    (rx_valid & first_q & ~rx_byte[DATA_W-1]),
    .time_i       (time_i),
    .alarm_flag_i (alarm_flag_i),
    .rd_addr_i    (ptr_q),
    .rd_data_o    (rd_data),
    .time_we_o    (time_we_o),
    .time_idx_o   (time_idx_o),
    .time_wdata_o (time_wdata_o),
    .alarm_o      (alarm_o),
    .ctrl_o       (ctrl_o),
    .trickle_o    (trickle_o)
  );
endmodule

// File: rtl/spi_rtc_chk.sv
module spi_rtc_chk
  import spi_rtc_pkg::*;
(
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    cs_act_i,
  input logic                    rx_valid_i,
  input logic                    miso_i,
  input logic                    time_we_i,
  input logic [TIME_IW-1:0]      time_idx_i,
  input logic [DATA_W-1:0]       ctrl_i,
  input logic [ALM_N*DATA_W-1:0] alarm_i
);
  AST_RX_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> !rx_valid_i); // R3
  AST_MISO_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_act_i && $past(!cs_act_i)) |-> !miso_i); // R3
  AST_WE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_we_i |=> !time_we_i); // R4
  AST_WE_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_we_i |-> (int'(time_idx_i) < TIME_N)); // R4
  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_i |=> $stable(ctrl_i)); // R6
  AST_WP_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_we_i |-> !$past(ctrl_i[WP_BIT])); // R9
  AST_WP_ALARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i[WP_BIT] |=> $stable(alarm_i)); // R9
endmodule

bind spi_rtc_slave spi_rtc_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_act_i   (cs_act),
  .rx_valid_i (rx_valid),
  .miso_i     (miso_o),
  .time_we_i  (time_we_o),
  .time_idx_i (time_idx_o),
  .ctrl_i     (ctrl_o),
  .alarm_i    (alarm_o)
);

// File: tb/tb_spi_rtc_slave.sv
module tb_spi_rtc_slave;
  localparam int HALF = 13;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sck_i = 1'b0, cs_i = 1'b0, mosi_i = 1'b0;
  logic        miso_o;
  logic [55:0] time_i = '0;
  logic [1:0]  alarm_flag_i = '0;
  logic        time_we_o;
  logic [2:0]  time_idx_o;
  logic [7:0]  time_wdata_o;
  logic [63:0] alarm_o;
  logic [7:0]  ctrl_o, trickle_o;

  int total = 0, bad = 0;
  bit done = 0;
  int ev_n = 0;
  logic [2:0] ev_idx [64];
  logic [7:0] ev_dat [64];

  always #10 clk_i = ~clk_i;

  spi_rtc_slave dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sck_i(sck_i), .cs_i(cs_i), .mosi_i(mosi_i),
    .miso_o(miso_o), .time_i(time_i), .alarm_flag_i(alarm_flag_i),
    .time_we_o(time_we_o), .time_idx_o(time_idx_o), .time_wdata_o(time_wdata_o),
    .alarm_o(alarm_o), .ctrl_o(ctrl_o), .trickle_o(trickle_o)
  );

  always @(posedge clk_i) begin
    if (rst_ni && time_we_o && ev_n < 64) begin
      ev_idx[ev_n] = time_idx_o;
      ev_dat[ev_n] = time_wdata_o;
      ev_n++;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic half_wait();
    repeat (HALF) @(negedge clk_i);
  endtask

  task automatic xbits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      sck_i = 1'b1; mosi_i = tx[i];
      half_wait();
      rx[i] = miso_o;
      sck_i = 1'b0;
      half_wait();
    end
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    xbits(tx, 8, rx);
  endtask

  task automatic cs_begin();
    @(negedge clk_i); cs_i = 1'b1;
    repeat (8) @(negedge clk_i);
  endtask

  task automatic cs_end();
    repeat (8) @(negedge clk_i); cs_i = 1'b0;
    repeat (10) @(negedge clk_i);
  endtask

  task automatic wr_burst(input logic [7:0] addr, input logic [7:0] d [], input int n);
    logic [7:0] r;
    cs_begin();
    xbyte(8'h80 | addr, r);
    for (int k = 0; k < n; k++) xbyte(d[k], r);
    cs_end();
  endtask

  task automatic rd_one(input logic [7:0] addr, output logic [7:0] v);
    logic [7:0] r;
    cs_begin();
    xbyte(addr & 8'h7F, r);
    xbyte(8'h00, v);
    cs_end();
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R10 ctrl", ctrl_o, 0);
    chk("R10 alarm", alarm_o, 0);
    chk("R10 trickle", trickle_o, 0);
    chk("R10 miso", miso_o, 0);
    chk("R10 time_we", time_we_o, 0);
    rd_one(8'h25, v);
    chk("R10 ram zero", v, 0);
  endtask

  task automatic t_time_write();
    logic [7:0] d [] = '{8'h30, 8'h59, 8'h12, 8'h03, 8'h25, 8'h12, 8'h99};
    int base = ev_n;
    wr_burst(8'h00, d, 7);
    chk("R4 event count", ev_n - base, 7);
    for (int k = 0; k < 7; k++) begin
      chk("R1 R2 R4 idx", ev_idx[base+k], k);
      chk("R4 data", ev_dat[base+k], d[k]);
    end
  endtask

  task automatic t_snapshot();
    logic [7:0] r;
    logic [55:0] orig = 56'h24_07_15_05_23_47_58;
    time_i = orig;
    cs_begin();
    xbyte(8'h00, r);
    chk("R3 miso zero in address byte", r, 0);
    time_i = 56'h24_07_15_05_23_48_00;
    for (int k = 0; k < 7; k++) begin
      xbyte(8'h00, r);
      chk("R5 snapshot byte", r, orig[k*8 +: 8]);
    end
    cs_end();
  endtask

  task automatic t_regs();
    logic [7:0] d [] = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08,
                         8'h05, 8'hFF, 8'hA5};
    logic [7:0] r;
    alarm_flag_i = 2'b10;
    wr_burst(8'h07, d, 11);
    chk("R6 alarm out", alarm_o, 64'h0807060504030201);
    chk("R6 ctrl out", ctrl_o, 8'h05);
    chk("R6 trickle out", trickle_o, 8'hA5);
    cs_begin();
    xbyte(8'h07, r);
    for (int k = 0; k < 8; k++) begin
      xbyte(8'h00, r);
      chk("R6 alarm readback", r, k + 1);
    end
    xbyte(8'h00, r); chk("R6 ctrl readback", r, 8'h05);
    xbyte(8'h00, r); chk("R7 status reads flags", r, 8'h02);
    xbyte(8'h00, r); chk("R6 trickle readback", r, 8'hA5);
    cs_end();
    alarm_flag_i = 2'b01;
    rd_one(8'h10, r);
    chk("R7 status follows flags", r, 8'h01);
  endtask

  task automatic t_unmapped();
    logic [7:0] d [] = new[15];
    logic [7:0] r;
    for (int k = 0; k < 14; k++) d[k] = 8'hAA;
    d[14] = 8'h3C;
    wr_burst(8'h12, d, 15);
    cs_begin();
    xbyte(8'h12, r);
    for (int k = 0; k < 14; k++) begin
      xbyte(8'h00, r);
      chk("R8 unmapped reads zero", r, 0);
    end
    xbyte(8'h00, r);
    chk("R6 ram readback", r, 8'h3C);
    cs_end();
  endtask

  task automatic t_wrap();
    logic [7:0] d [] = '{8'h11, 8'h22, 8'h33};
    logic [7:0] r;
    int base = ev_n;
    time_i = 56'h00_00_00_00_00_00_5A;
    wr_burst(8'h7E, d, 3);
    chk("R2 wrap event count", ev_n - base, 1);
    chk("R2 wrap idx", ev_idx[base], 0);
    chk("R2 wrap data", ev_dat[base], 8'h33);
    cs_begin();
    xbyte(8'h7E, r);
    xbyte(8'h00, r); chk("R2 ram 7E", r, 8'h11);
    xbyte(8'h00, r); chk("R2 ram 7F", r, 8'h22);
    xbyte(8'h00, r); chk("R2 read wraps to time", r, 8'h5A);
    cs_end();
  endtask

  task automatic t_wp();
    logic [7:0] d1 [] = '{8'h45};
    logic [7:0] d2 [] = '{8'hEE};
    logic [7:0] d3 [] = '{8'h77};
    logic [7:0] d4 [] = '{8'h05};
    logic [7:0] r;
    int base;
    wr_burst(8'h0F, d1, 1);
    chk("R9 ctrl set", ctrl_o, 8'h45);
    wr_burst(8'h07, d2, 1);
    chk("R9 alarm blocked", alarm_o[7:0], 8'h01);
    wr_burst(8'h20, d3, 1);
    rd_one(8'h20, r);
    chk("R9 ram blocked", r, 8'h3C);
    base = ev_n;
    wr_burst(8'h00, d2, 1);
    chk("R9 time load blocked", ev_n - base, 0);
    wr_burst(8'h11, d2, 1);
    chk("R9 trickle blocked", trickle_o, 8'hA5);
    wr_burst(8'h0F, d4, 1);
    chk("R9 ctrl writable", ctrl_o, 8'h05);
  endtask

  task automatic t_abort();
    logic [7:0] r;
    cs_begin();
    xbyte(8'hA0, r);
    xbits(8'hFF, 4, r);
    cs_end();
    rd_one(8'h20, r);
    chk("R11 partial byte dropped", r, 8'h3C);
    cs_begin();
    xbyte(8'h87, r);
    xbits(8'h0F, 5, r);
    cs_end();
    chk("R11 alarm unchanged", alarm_o[7:0], 8'h01);
  endtask

  initial begin
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    t_reset();
    t_time_write();
    t_snapshot();
    t_regs();
    t_unmapped();
    t_wrap();
    t_wp();
    t_abort();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule